// File: doc/BRIEF.md
# MDIO Management Master

This block is a host-programmable master for the two-wire PHY management interface (MDC clock, bidirectional MDIO data). A host reaches six registers through a simple synchronous register port: an MDC divider, a command register, a combined PHY/register address register, a write-data register, a read-data register and a status register. Writing a command with a read or write bit set launches one clause-22 management frame. The block clocks the frame out on MDIO with MDC toggling at the programmed rate, releases the line where the PHY is expected to answer, and captures read data.

A transfer always runs to completion. While a frame is in flight the status register shows busy, and any further command is ignored. When the frame ends, the captured data of a read lands in the read-data register and the status returns to zero. The MDIO pin is split into an output value and an output enable, so the pad-level tri-state buffer sits outside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset the command, address, write-data, read-data and status registers read 0, and the divider reads the parameter DIV_RESET (100 by default).
- R2: Register selects are 0 divider, 1 command, 2 address, 3 write data, 4 read data and 5 status. Selects 6 and 7 read 0. The divider reads back its 8-bit value. The command register reads back bits 2:0 of the last value written. The write-data register reads back all 16 bits. The address register reads back the PHY address in bits 4:0 and the register address in bits 12:8, with every other bit 0.
- R3: Read data (select 4) and status (select 5) are read-only, and a write to them changes nothing.
- R4: A command write with bit 1 set starts a read. A command write with bit 2 set and bit 1 clear starts a write. A command write with both bits set starts a read. A command write with neither bit set starts no frame.
- R5: A frame is 64 MDC periods long, sent most significant bit first: 32 ones, start 01, opcode 10 for a read or 01 for a write, the PHY address (5 bits), the register address (5 bits), turnaround, and 16 data bits. In a write the turnaround is 10 and the data are the write-data register.
- R6: Every MDC period lasts the divider value in system clocks, and a divider below 2 counts as 2. MDC rises after floor(div/2) clocks of each period.
- R7: The output enable is high for all 64 bits of a write. In a read it is high for the first 46 bits and low from the turnaround onward.
- R8: A read samples MDIO in the clock just before each of the 16 data-phase MDC rising edges. At the end of the frame it places the result, first sample in bit 15, into the read-data register.
- R9: Status bit 0 (busy) reads 1 from the clock after the command write for exactly 64 × divider clocks, then reads 0. With a divider of 4 this is within 768 clocks.
- R10: A command written while busy starts no frame and does not alter the frame in progress, although the command register still reads it back.
- R11: While idle, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register select for reads and writes |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 16 | Write value |
| regRdData | output | 16 | Combinational read value of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value to drive when enabled |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen at the pin |

## Verification
The bound assertions check, on every cycle, that MDC and the output enable stay low while idle, that busy only ever rises after a command write carrying a start bit, and that every frame begins with the line driven. Frame content, the exact length of busy for each divider, the clamping of small dividers, the release point of a read, the assembly of the read data and the rejection of commands during a frame can only be shown by the bench. It does this with a PHY model that records every bit at each MDC rising edge and feeds a known pattern back.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    SEL_DIV    = 3'd0,
    SEL_CMD    = 3'd1,
    SEL_ADDR   = 3'd2,
    SEL_WDATA  = 3'd3,
    SEL_RDATA  = 3'd4,
    SEL_STATUS = 3'd5
  } regSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // accept a command and build the frame
    logic shift;   // advance to the next frame bit
    logic sample;  // capture MDIO during the read data phase
    logic finish;  // last bit period ends
  } mdioStrobe_t;

  localparam int CMD_READ_BIT  = 1;
  localparam int CMD_WRITE_BIT = 2;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FRAME_LEN  = 64,
  parameter int OE_REL_IDX = 46,
  parameter int SAMPLE_IDX = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             startRead,
  input  logic [DIV_W-1:0] divider,
  output mdioStrobe_t      strobe,
  output logic             busy,
  output logic             mdc,
  output logic             mdioOe
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [DIV_W-1:0] divLat, cnt, halfDiv, divEff;
  logic [IDX_W-1:0] bitIdx;
  logic             isRead;
  logic             endPeriod, lastBit, riseNow;

  always_comb begin
    divEff    = (divider < DIV_W'(2)) ? DIV_W'(2) : divider;
    halfDiv   = divLat >> 1;
    endPeriod = busy && (cnt == divLat - DIV_W'(1));
    riseNow   = busy && (cnt == halfDiv - DIV_W'(1));
    lastBit   = (bitIdx == IDX_W'(FRAME_LEN - 1));
    strobe.load   = startReq && !busy;
    strobe.shift  = endPeriod && !lastBit;
    strobe.finish = endPeriod && lastBit;
    strobe.sample = riseNow && isRead && (bitIdx >= IDX_W'(SAMPLE_IDX));
    mdioOe        = busy && (!isRead || (bitIdx < IDX_W'(OE_REL_IDX)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      bitIdx <= '0;
      isRead <= 1'b0;
      mdc    <= 1'b0;
      divLat <= DIV_W'(2);
    end else if (strobe.load) begin
      busy   <= 1'b1;
      cnt    <= '0;
      bitIdx <= '0;
      isRead <= startRead;
      mdc    <= 1'b0;
      divLat <= divEff;
    end else if (busy) begin
      if (endPeriod) begin
        cnt <= '0;
        mdc <= 1'b0;
        if (lastBit) busy <= 1'b0;
        else         bitIdx <= bitIdx + IDX_W'(1);
      end else begin
        cnt <= cnt + DIV_W'(1);
        if (riseNow) mdc <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 100,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int PRE_LEN   = 32,
  parameter int REG_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  mdioStrobe_t       strobe,
  input  logic              busy,
  input  logic              mdioIn,
  output logic              startReq,
  output logic              startRead,
  output logic [DIV_W-1:0]  divider,
  output logic              mdioOut
);
  localparam int FRAME_LEN = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;

  logic [2:0]           cmdReg;
  logic [ADDR_W-1:0]    phyAddr, regAddr;
  logic [DATA_W-1:0]    wdataReg, rdataReg, capture;
  logic [FRAME_LEN-1:0] frame;
  logic                 wrDiv, wrCmd, wrAddr, wrData;

  always_comb begin
    wrDiv     = regWrEn && (regSel == SEL_DIV);
    wrCmd     = regWrEn && (regSel == SEL_CMD);
    wrAddr    = regWrEn && (regSel == SEL_ADDR);
    wrData    = regWrEn && (regSel == SEL_WDATA);
    startRead = regWrData[CMD_READ_BIT];
    startReq  = wrCmd && (regWrData[CMD_READ_BIT] || regWrData[CMD_WRITE_BIT]);
    mdioOut   = busy ? frame[FRAME_LEN-1] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divider  <= DIV_W'(DIV_RESET);
      cmdReg   <= '0;
      phyAddr  <= '0;
      regAddr  <= '0;
      wdataReg <= '0;
    end else begin
      if (wrDiv)  divider  <= regWrData[DIV_W-1:0];
      if (wrCmd)  cmdReg   <= regWrData[2:0];
      if (wrAddr) begin
        phyAddr <= regWrData[ADDR_W-1:0];
        regAddr <= regWrData[REG_SHIFT +: ADDR_W];
      end
      if (wrData) wdataReg <= regWrData;
    end
  end

  // frame shift register and read capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame    <= '0;
      capture  <= '0;
      rdataReg <= '0;
    end else begin
      if (strobe.load)
        frame <= {{PRE_LEN{1'b1}}, 2'b01,
                  (startRead ? 2'b10 : 2'b01),
                  phyAddr, regAddr, 2'b10, wdataReg};
      else if (strobe.shift)
        frame <= {frame[FRAME_LEN-2:0], 1'b0};
      if (strobe.sample) capture <= {capture[DATA_W-2:0], mdioIn};
      if (strobe.finish) rdataReg <= capture;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regSel)
      SEL_DIV:    regRdData[DIV_W-1:0] = divider;
      SEL_CMD:    regRdData[2:0] = cmdReg;
      SEL_ADDR: begin
        regRdData[ADDR_W-1:0]         = phyAddr;
        regRdData[REG_SHIFT +: ADDR_W] = regAddr;
      end
      SEL_WDATA:  regRdData = wdataReg;
      SEL_RDATA:  regRdData = rdataReg;
      SEL_STATUS: regRdData[0] = busy;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 100,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regSel,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  localparam int ADDR_W     = 5;
  localparam int FRAME_LEN  = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
  localparam int OE_REL_IDX = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int SAMPLE_IDX = OE_REL_IDX + 2;

  mdioStrobe_t      strobe;
  logic             busy, startReq, startRead;
  logic [DIV_W-1:0] divider;

  mdio_ctrl #(
    .DIV_W(DIV_W), .FRAME_LEN(FRAME_LEN),
    .OE_REL_IDX(OE_REL_IDX), .SAMPLE_IDX(SAMPLE_IDX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startRead(startRead),
    .divider(divider), .strobe(strobe), .busy(busy), .mdc(mdc),
    .mdioOe(mdioOe)
  );

  mdio_dpath #(
    .DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .PRE_LEN(PRE_LEN), .REG_SHIFT(8)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .busy(busy), .mdioIn(mdioIn), .startReq(startReq),
    .startRead(startRead), .divider(divider), .mdioOut(mdioOut)
  );
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              mdc,
  input logic              mdioOe,
  input logic [2:0]        regSel,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData
);
  assert_mdc_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  assert_start_from_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWrEn && (regSel == 3'd1) &&
                          (regWrData[1] || regWrData[2])));

  assert_preamble_driven_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> mdioOe);

  assert_mdc_low_at_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !mdc);
endmodule

bind mdio_master mdio_master_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .mdc(mdc), .mdioOe(mdioOe),
  .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  regSel;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: record each bit at MDC rise, answer reads with rdPat
  int          riseCnt = 0;
  int          base = 0;
  logic [63:0] capBits = '0;
  logic [63:0] capOe = '0;
  logic [15:0] rdPat = '0;

  always @(posedge mdc) begin
    riseCnt <= riseCnt + 1;
    capBits <= {capBits[62:0], mdioOe & mdioOut};
    capOe   <= {capOe[62:0], mdioOe};
  end

  always_comb begin
    int idx;
    idx = riseCnt - base;
    mdioIn = (idx >= 48 && idx < 64) ? rdPat[63 - idx] : 1'b1;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    regSel = s; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] s, output logic [15:0] d);
    @(negedge clk);
    regSel = s;
    #1 d = regRdData;
  endtask

  // from the negedge after the command write, count cycles with busy set
  task automatic countBusy(output int n);
    n = 0;
    regSel = 3'd5;
    #1;
    while (regRdData[0] && n < 5000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic doXfer(input logic [15:0] cmdVal, input int div,
                        input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] data);
    bit isRead;
    int eff, n;
    logic [63:0] expFrame, expOe;
    logic [15:0] v;
    isRead = cmdVal[1];
    eff = (div < 2) ? 2 : div;
    regWr(3'd0, 16'(div));
    regWr(3'd2, {3'b0, ra, 3'b0, phy});
    if (!isRead) regWr(3'd3, data);
    rdPat = data;
    base = riseCnt;
    regWr(3'd1, cmdVal);
    countBusy(n);
    check("R9", "busy length", 64'(n), 64'(64 * eff));
    if (div == 4) check("R9", "within 768", 64'(n <= 768), 64'd1);
    check("R6", "mdc rises per frame", 64'(riseCnt - base), 64'd64);
    expFrame = {32'hFFFF_FFFF, 2'b01, (isRead ? 2'b10 : 2'b01),
                phy, ra, 2'b10, data};
    expOe = isRead ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    check("R7", "output enable pattern", capOe, expOe);
    check("R5", "frame bits", capBits & expOe, expFrame & expOe);
    if (isRead) begin
      regRd(3'd4, v);
      check("R8", "read data", 64'(v), 64'(data));
    end
    regRd(3'd1, v);
    check("R2", "command readback", 64'(v), 64'(cmdVal[2:0]));
    check("R11", "idle mdc/oe", {62'b0, mdc, mdioOe}, 64'd0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    int startCnt;
    rstN = 1'b0; regSel = 3'd0; regWrEn = 1'b0; regWrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    regRd(3'd0, v); check("R1", "divider reset", 64'(v), 64'd100);
    for (int s = 1; s < 6; s++) begin
      regRd(3'(s), v); check("R1", "register reset", 64'(v), 64'd0);
    end
    check("R11", "idle after reset", {62'b0, mdc, mdioOe}, 64'd0);

    // R2 register readback and unused selects
    regWr(3'd0, 16'h00C7); regRd(3'd0, v); check("R2", "divider", 64'(v), 64'h00C7);
    regWr(3'd2, 16'hFFFF); regRd(3'd2, v); check("R2", "address", 64'(v), 64'h1F1F);
    regWr(3'd2, 16'h1F00); regRd(3'd2, v); check("R2", "address reg field", 64'(v), 64'h1F00);
    regWr(3'd3, 16'hAAAA); regRd(3'd3, v); check("R2", "write data", 64'(v), 64'hAAAA);
    regRd(3'd6, v); check("R2", "select 6", 64'(v), 64'd0);
    regRd(3'd7, v); check("R2", "select 7", 64'(v), 64'd0);

    // R3 read-only registers
    regWr(3'd4, 16'h1234); regRd(3'd4, v); check("R3", "read data untouched", 64'(v), 64'd0);
    regWr(3'd5, 16'hFFFF); regRd(3'd5, v); check("R3", "status untouched", 64'(v), 64'd0);

    // R4 no start bits: no frame
    regWr(3'd0, 16'd4);
    startCnt = riseCnt;
    regWr(3'd1, 16'h0001);
    repeat (100) @(negedge clk);
    check("R4", "no frame without start bit", 64'(riseCnt - startCnt), 64'd0);
    regRd(3'd5, v); check("R4", "status idle", 64'(v), 64'd0);
    regRd(3'd1, v); check("R2", "command readback bit0", 64'(v), 64'd1);

    // sweep of dividers, reads and writes
    for (int d = 0; d < 8; d++) begin
      doXfer(16'h0002, d, 5'((d * 7 + 3) & 31), 5'((d * 11 + 5) & 31),
             16'hA5C3 ^ 16'(d * 16'h1357));
      doXfer(16'h0004, d, 5'((d * 13 + 1) & 31), 5'((d * 5 + 9) & 31),
             16'h3C96 ^ 16'(d * 16'h0F21));
    end
    // address extremes
    doXfer(16'h0002, 4, 5'h1F, 5'h00, 16'h8001);
    doXfer(16'h0004, 4, 5'h00, 5'h1F, 16'hAAAA);
    // R4 both bits: read
    doXfer(16'h0006, 3, 5'h0A, 5'h15, 16'h5A5A);

    // R10 command while busy is ignored
    regWr(3'd0, 16'd4);
    regWr(3'd2, {3'b0, 5'h11, 3'b0, 5'h06});
    rdPat = 16'hC0DE;
    base = riseCnt;
    regWr(3'd1, 16'h0002);
    repeat (20) @(negedge clk);
    regWr(3'd1, 16'h0004);
    begin
      int n;
      countBusy(n);
      check("R10", "busy length unchanged", 64'(n + 22), 64'(256));
    end
    check("R10", "single frame", 64'(riseCnt - base), 64'd64);
    check("R10", "frame stayed a read", capOe, {{46{1'b1}}, 18'b0});
    regRd(3'd4, v); check("R10", "read data", 64'(v), 64'hC0DE);
    repeat (300) @(negedge clk);
    check("R10", "no late frame", 64'(riseCnt - base), 64'd64);
    regRd(3'd5, v); check("R10", "status idle", 64'(v), 64'd0);
    regRd(3'd1, v); check("R10", "command readback", 64'(v), 64'd4);

    finishRun();
  end
endmodule